// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It steps the analog front end through a repeating loop of four phases. The first is auto-zero. Next comes input integrate, which lasts a fixed time. Then comes reference deintegrate, which ends when the integrator output crosses zero. Last is integrator zero. The block drives one-hot select lines to the analog switches and an active-low end-of-conversion flag that falls whenever auto-zero begins. At the end of every completed loop it publishes a result word made of an overrange bit, a sign bit and a deintegrate count.

All timing runs from an internal tick, which is the input clock divided by `CLK_DIV`. Auto-zero and integrate share one length. That length is set by a `LOAD_W`-bit load value L. L is preloaded into the upper part of a timebase counter, whose lower `PRE_W` bits act as a prescaler. The counter then counts up to overflow. With the defaults, each of these phases lasts (256 − L) × 1024 input clocks.

The analog comparator reaches the block as a single logic level, `cmpIn`. The level seen on the last integrate tick becomes the sign. Any later difference from that level counts as a zero crossing. A high level on `holdIn` parks the machine in auto-zero. A strobe on `loadStb` installs a new load value and restarts the loop from auto-zero.

Top module: `dual_slope_seq`

## Requirements
- R1: While `rstN` is low the block enters auto-zero: `phaseSel` = 4'b0001, `eocN` = 0, and `resOvr`, `resSign` and `resCnt` are all zero.
- R2: Exactly one bit of `phaseSel` is set at any time. The encoding is bit 0 auto-zero, bit 1 integrate, bit 2 deintegrate, bit 3 integrator zero. Without hold or load, the phases always advance in the order 0, 1, 2, 3, 0.
- R3: Auto-zero and integrate each last exactly (2^LOAD_W − L) · 2^PRE_W · CLK_DIV input clocks, where L is the active load value.
- R4: Deintegrate ends on the first tick at which `cmpIn` differs from the captured sign. The published count equals the number of deintegrate ticks that came before that tick, so deintegrate lasts count + 1 ticks.
- R5: Let N be the integrate length in ticks. If no crossing is seen by tick 2N of deintegrate, deintegrate ends after 2N ticks with `resOvr` = 1 and `resCnt` all ones. A crossing seen on tick 2N wins: `resOvr` = 0 and `resCnt` = 2N − 1.
- R6: `resSign` equals the level of `cmpIn` on the last tick of integrate. Changes of `cmpIn` earlier in auto-zero or integrate have no effect.
- R7: Integrator zero ends on the first tick at which `cmpIn` differs from the captured sign, and otherwise after `IZ_TICKS` ticks.
- R8: `eocN` is low during every cycle of auto-zero and high in all other phases.
- R9: The result outputs change only on the edge that ends integrator zero and starts auto-zero, and they hold until the next completed loop. A loop that is cut short by hold or load publishes nothing.
- R10: While `holdIn` is high, the machine is in auto-zero from the next edge onward. After release, a full auto-zero length is counted before integrate starts.
- R11: `loadStb` captures `loadIn` and restarts auto-zero on the next edge, and the new value sets the auto-zero and integrate lengths from then on. `loadIn` without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset |
| holdIn | input | 1 | High level holds the converter in auto-zero |
| loadStb | input | 1 | One-cycle strobe that installs `loadIn` and restarts the loop |
| loadIn | input | LOAD_W | Timebase load value from the serial port |
| cmpIn | input | 1 | Zero-crossing comparator level |
| phaseSel | output | 4 | One-hot phase select (auto-zero, integrate, deintegrate, integrator zero) |
| eocN | output | 1 | Active-low end-of-conversion, low during auto-zero |
| resOvr | output | 1 | Overrange bit of the last result |
| resSign | output | 1 | Sign bit of the last result |
| resCnt | output | CNT_W | Deintegrate count of the last result |

## Verification
Two functions can act on the same deintegrate tick: zero-crossing detection and the overrange cap at twice the integrate length. The bench provokes this case by flipping `cmpIn` so that the crossing is first seen on tick 2N. It then requires a non-overrange result with count 2N − 1 and a deintegrate length of exactly 2N ticks. One tick later the cap takes over: that run must return overrange with a saturated count. Every load value of a reduced configuration is swept through both cases, and the count-zero case is swept as well.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2,
    PH_IZ    = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;       // one timebase tick (not during restart)
    logic restart;    // hold or load forces auto-zero
    logic phaseEnd;   // current phase ends on this tick
    logic latchSign;  // last integrate tick
    logic endDe;      // deintegrate ends on this tick
    logic publish;    // loop complete, move result to outputs
    logic countDe;    // advance deintegrate counter
    logic countIz;    // advance integrator-zero counter
  } ctl_s;

  // status from datapath to control
  typedef struct packed {
    logic tbDone;   // timebase counter at its last value
    logic crossed;  // comparator differs from captured sign
    logic deCap;    // deintegrate at its limit tick
    logic izDone;   // integrator zero at its limit tick
  } sts_s;

endpackage

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   holdIn,
  input  logic   loadStb,
  input  sts_s   sts,
  output ctl_s   ctl,
  output phase_e phase
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic             restart;
  logic             tick;
  logic             advance;
  phase_e           nextPhase;

  always_comb begin
    restart = holdIn | loadStb;
    tick    = (divCnt == DIV_LAST) && !restart;
  end

  always_comb begin
    advance   = 1'b0;
    nextPhase = phase;
    case (phase)
      PH_AZ: begin
        advance   = sts.tbDone;
        nextPhase = PH_INT;
      end
      PH_INT: begin
        advance   = sts.tbDone;
        nextPhase = PH_DEINT;
      end
      PH_DEINT: begin
        advance   = sts.crossed | sts.deCap;
        nextPhase = PH_IZ;
      end
      default: begin
        advance   = sts.crossed | sts.izDone;
        nextPhase = PH_AZ;
      end
    endcase
  end

  always_comb begin
    ctl.tick      = tick;
    ctl.restart   = restart;
    ctl.phaseEnd  = tick && advance;
    ctl.latchSign = tick && advance && (phase == PH_INT);
    ctl.endDe     = tick && advance && (phase == PH_DEINT);
    ctl.publish   = tick && advance && (phase == PH_IZ);
    ctl.countDe   = tick && !advance && (phase == PH_DEINT);
    ctl.countIz   = tick && !advance && (phase == PH_IZ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_AZ;
      divCnt <= '0;
    end else if (restart) begin
      phase  <= PH_AZ;
      divCnt <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick && advance) begin
        phase <= nextPhase;
      end
    end
  end

endmodule

// File: rtl/dss_datapath.sv
module dss_datapath
  import dss_pkg::*;
#(
  parameter int LOAD_W   = 8,
  parameter int PRE_W    = 8,
  parameter int CNT_W    = 17,
  parameter int IZ_TICKS = 256,
  parameter logic [LOAD_W-1:0] DEF_LOAD = {1'b1, {(LOAD_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [LOAD_W-1:0] loadIn,
  input  logic              cmpIn,
  input  ctl_s              ctl,
  output sts_s              sts,
  output logic              resOvr,
  output logic              resSign,
  output logic [CNT_W-1:0]  resCnt
);

  localparam int TB_W = LOAD_W + PRE_W;
  localparam int IZ_W = $clog2(IZ_TICKS + 1);
  localparam logic [IZ_W-1:0] IZ_LAST = IZ_W'(IZ_TICKS - 1);
  localparam logic [PRE_W-1:0] PRE_ZERO = '0;

  logic [LOAD_W-1:0] loadReg;
  logic [TB_W-1:0]   tbCnt;
  logic [TB_W:0]     intTicks;
  logic [TB_W+1:0]   deSpan;
  logic [CNT_W-1:0]  deLimit;
  logic [CNT_W-1:0]  deCnt;
  logic [IZ_W-1:0]   izCnt;
  logic              signReg;
  logic              pendOvr;
  logic [CNT_W-1:0]  pendCnt;

  // integrate length in ticks, deintegrate limit is twice that, minus one
  always_comb begin
    intTicks = {1'b1, {TB_W{1'b0}}} - {1'b0, loadReg, PRE_ZERO};
    deSpan   = {intTicks, 1'b0} - {{(TB_W+1){1'b0}}, 1'b1};
    deLimit  = CNT_W'(deSpan);
  end

  always_comb begin
    sts.tbDone  = &tbCnt;
    sts.crossed = cmpIn ^ signReg;
    sts.deCap   = (deCnt == deLimit);
    sts.izDone  = (izCnt == IZ_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg <= DEF_LOAD;
    end else if (loadStb) begin
      loadReg <= loadIn;
    end
  end

  // preloaded timebase counting up to overflow
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tbCnt <= {DEF_LOAD, PRE_ZERO};
    end else if (ctl.restart) begin
      tbCnt <= {(loadStb ? loadIn : loadReg), PRE_ZERO};
    end else if (ctl.phaseEnd) begin
      tbCnt <= {loadReg, PRE_ZERO};
    end else if (ctl.tick) begin
      tbCnt <= tbCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.restart || ctl.phaseEnd) begin
      deCnt <= '0;
    end else if (ctl.countDe) begin
      deCnt <= deCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.restart || ctl.phaseEnd) begin
      izCnt <= '0;
    end else if (ctl.countIz) begin
      izCnt <= izCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      signReg <= 1'b0;
    end else if (ctl.latchSign) begin
      signReg <= cmpIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendOvr <= 1'b0;
      pendCnt <= '0;
    end else if (ctl.endDe) begin
      pendOvr <= !sts.crossed;
      pendCnt <= sts.crossed ? deCnt : {CNT_W{1'b1}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOvr  <= 1'b0;
      resSign <= 1'b0;
      resCnt  <= '0;
    end else if (ctl.publish) begin
      resOvr  <= pendOvr;
      resSign <= signReg;
      resCnt  <= pendCnt;
    end
  end

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int LOAD_W   = 8,
  parameter int PRE_W    = 8,
  parameter int CNT_W    = 17,
  parameter int IZ_TICKS = 256,
  parameter logic [LOAD_W-1:0] DEF_LOAD = {1'b1, {(LOAD_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdIn,
  input  logic              loadStb,
  input  logic [LOAD_W-1:0] loadIn,
  input  logic              cmpIn,
  output logic [3:0]        phaseSel,
  output logic              eocN,
  output logic              resOvr,
  output logic              resSign,
  output logic [CNT_W-1:0]  resCnt
);

  ctl_s   ctl;
  sts_s   sts;
  phase_e phase;

  dss_ctrl #(
    .CLK_DIV(CLK_DIV)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .holdIn (holdIn),
    .loadStb(loadStb),
    .sts    (sts),
    .ctl    (ctl),
    .phase  (phase)
  );

  dss_datapath #(
    .LOAD_W  (LOAD_W),
    .PRE_W   (PRE_W),
    .CNT_W   (CNT_W),
    .IZ_TICKS(IZ_TICKS),
    .DEF_LOAD(DEF_LOAD)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .loadStb(loadStb),
    .loadIn (loadIn),
    .cmpIn  (cmpIn),
    .ctl    (ctl),
    .sts    (sts),
    .resOvr (resOvr),
    .resSign(resSign),
    .resCnt (resCnt)
  );

  always_comb begin
    case (phase)
      PH_AZ:    phaseSel = 4'b0001;
      PH_INT:   phaseSel = 4'b0010;
      PH_DEINT: phaseSel = 4'b0100;
      default:  phaseSel = 4'b1000;
    endcase
    eocN = (phase != PH_AZ);
  end

endmodule

// File: rtl/dss_chk.sv
module dss_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rstN,
  input logic             holdIn,
  input logic             loadStb,
  input logic [3:0]       phaseSel,
  input logic             eocN,
  input logic             resOvr,
  input logic             resSign,
  input logic [CNT_W-1:0] resCnt
);

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(phaseSel) == 1);

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(phaseSel) && !$past(holdIn) && !$past(loadStb))
      |-> (phaseSel == {$past(phaseSel[2:0]), $past(phaseSel[3])}));

  // R10
  hold_az_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdIn |=> (phaseSel == 4'b0001 && !eocN));

  // R11
  load_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (phaseSel == 4'b0001));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(eocN) |-> $stable({resOvr, resSign, resCnt}));

  // R5
  ovr_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    resOvr |-> (&resCnt));

endmodule

bind dual_slope_seq dss_chk #(
  .CNT_W(CNT_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .holdIn  (holdIn),
  .loadStb (loadStb),
  .phaseSel(phaseSel),
  .eocN    (eocN),
  .resOvr  (resOvr),
  .resSign (resSign),
  .resCnt  (resCnt)
);

// File: tb/tb_dual_slope_seq.sv
module tb_dual_slope_seq;

  localparam int CLK_DIV  = 4;
  localparam int PRE_W    = 2;
  localparam int LOAD_W   = 4;
  localparam int CNT_W    = 17;
  localparam int IZ_TICKS = 8;
  localparam int SPAN     = 1 << LOAD_W;
  localparam longint FULL = (64'd1 << CNT_W) - 1;
  localparam logic [3:0] P_AZ = 4'b0001, P_INT = 4'b0010, P_DE = 4'b0100, P_IZ = 4'b1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdIn = 1'b1;
  logic loadStb = 1'b0;
  logic [LOAD_W-1:0] loadIn = '0;
  logic cmpIn = 1'b0;
  logic [3:0] phaseSel;
  logic eocN, resOvr, resSign;
  logic [CNT_W-1:0] resCnt;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  longint lastCnt = 0;
  bit lastOvr = 0, lastSign = 0;

  dual_slope_seq #(
    .CLK_DIV(CLK_DIV), .LOAD_W(LOAD_W), .PRE_W(PRE_W), .CNT_W(CNT_W),
    .IZ_TICKS(IZ_TICKS), .DEF_LOAD(4'd8)
  ) dut (
    .clk(clk), .rstN(rstN), .holdIn(holdIn), .loadStb(loadStb), .loadIn(loadIn),
    .cmpIn(cmpIn), .phaseSel(phaseSel), .eocN(eocN), .resOvr(resOvr),
    .resSign(resSign), .resCnt(resCnt)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkHeld(string req);
    chk(req, "held overrange", resOvr, lastOvr);
    chk(req, "held sign", resSign, lastSign);
    chk(req, "held count", resCnt, lastCnt);
  endtask

  task automatic gotoPhase(logic [3:0] p);
    while (phaseSel != p) @(negedge clk);
  endtask

  task automatic pulseLoad(int val);
    loadIn  = LOAD_W'(val);
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    loadIn  = ~LOAD_W'(val);   // stray value without strobe must be ignored (R11)
  endtask

  // Starts on the first auto-zero sample; ends on the first sample of the next auto-zero.
  // c: tick on which the crossing is first seen minus one; f: IZ tick of early crossing (0 none)
  task automatic runConv(int L, bit s, int c, int f, bit wiggle);
    int a, maxDe, n, expIz, expDe;
    longint expCnt;
    bit expOvr, eocBad;
    a = (SPAN - L) * (1 << PRE_W);
    maxDe = 2 * a;
    expOvr = (c >= maxDe);
    expCnt = expOvr ? FULL : c;
    expDe = expOvr ? maxDe * CLK_DIV : (c + 1) * CLK_DIV;
    expIz = !expOvr ? CLK_DIV : ((f > 0) ? f * CLK_DIV : IZ_TICKS * CLK_DIV);
    eocBad = 0;
    cmpIn = wiggle ? !s : s;
    n = 0;
    while (phaseSel == P_AZ) begin
      n++; if (eocN !== 1'b0) eocBad = 1; @(negedge clk);
    end
    chk("R3", "auto-zero length", n, a * CLK_DIV);
    chk("R2", "phase after auto-zero", phaseSel, P_INT);
    n = 0;
    while (phaseSel == P_INT) begin
      n++; if (eocN !== 1'b1) eocBad = 1;
      if (wiggle && n == 2) cmpIn = s;
      @(negedge clk);
    end
    chk("R3", "integrate length", n, a * CLK_DIV);
    chk("R2", "phase after integrate", phaseSel, P_DE);
    n = 0;
    while (phaseSel == P_DE) begin
      n++; if (eocN !== 1'b1) eocBad = 1;
      if (n == 4 * c + 2) cmpIn = !s;
      @(negedge clk);
    end
    chk(expOvr ? "R5" : "R4", "deintegrate length", n, expDe);
    chk("R2", "phase after deintegrate", phaseSel, P_IZ);
    n = 0;
    while (phaseSel == P_IZ) begin
      n++; if (eocN !== 1'b1) eocBad = 1;
      if (f > 0 && n == 4 * (f - 1) + 2) cmpIn = !s;
      @(negedge clk);
    end
    chk("R7", "integrator zero length", n, expIz);
    chk("R2", "phase after integrator zero", phaseSel, P_AZ);
    chk("R8", "eocN pattern", {eocBad, eocN}, 0);
    chk("R6", "sign", resSign, s);
    chk("R5", "overrange", resOvr, expOvr);
    chk(expOvr ? "R5" : "R4", "count", resCnt, expCnt);
    lastOvr = expOvr; lastSign = s; lastCnt = expCnt;
  endtask

  initial begin
    int a;
    bit bad;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "phaseSel after reset", phaseSel, P_AZ);
    chk("R1", "eocN after reset", eocN, 0);
    chk("R1", "result after reset", {resOvr, resSign, resCnt}, 0);
    repeat (40) @(negedge clk);
    chk("R10", "phase while held", phaseSel, P_AZ);

    holdIn = 1'b0;
    runConv(8, 1, 5, 0, 0);      // default load value
    runConv(8, 0, 0, 0, 1);      // sign input wiggles during integrate (R6)

    for (int L = 0; L < SPAN; L++) begin
      a = (SPAN - L) * (1 << PRE_W);
      pulseLoad(L);
      runConv(L, L[0], 0, 0, 0);
      runConv(L, !L[0], 2 * a - 1, 0, 0);      // crossing on the cap tick (R5)
      runConv(L, 1, 2 * a, (L % 3 == 0) ? 0 : (L % 8) + 1, 0);  // overrange
      if (L % 4 == 1) runConv(L, 0, a, 0, L[1]);
    end

    // hold in the middle of integrate: nothing published (R10, R9)
    gotoPhase(P_INT);
    repeat (3) @(negedge clk);
    holdIn = 1'b1;
    @(negedge clk);
    bad = 0;
    repeat (12) begin
      if (phaseSel != P_AZ || eocN != 1'b0) bad = 1;
      @(negedge clk);
    end
    chk("R10", "held in auto-zero", bad, 0);
    checkHeld("R9");
    holdIn = 1'b0;
    runConv(SPAN - 1, 1, 3, 0, 0);

    // hold during deintegrate
    cmpIn = 1'b0;
    gotoPhase(P_DE);
    repeat (5) @(negedge clk);
    holdIn = 1'b1;
    @(negedge clk);
    chk("R10", "hold from deintegrate", phaseSel, P_AZ);
    checkHeld("R9");
    @(negedge clk);
    holdIn = 1'b0;
    runConv(SPAN - 1, 0, 2, 0, 0);

    // load strobe during deintegrate restarts with the new value (R11)
    cmpIn = 1'b1;
    gotoPhase(P_DE);
    repeat (3) @(negedge clk);
    pulseLoad(3);
    chk("R11", "restart phase", phaseSel, P_AZ);
    checkHeld("R9");
    runConv(3, 1, 7, 0, 0);
    runConv(3, 0, 52, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule